// File: doc/BRIEF.md
# Four-Way Unified Read-Allocate Cache

This block is a 4-Kbyte mixed instruction and data cache that sits between a 32-bit processor request port and an external memory port. It is indexed and tagged directly by the virtual address the processor presents. There are 64 sets of four ways, and each line holds four 32-bit words. A read that hits is answered in the same cycle from the cache arrays.

A read that misses consults a per-request cacheable flag. With the flag set, the cache fetches the whole line as a four-beat burst and installs it in a way drawn from a free-running pseudo-random generator. With the flag clear, it makes one single-word external read and leaves the arrays untouched.

Every processor write goes out to memory. A write that hits also updates the cached word; a write that misses allocates nothing. A level enable input gates the cache, and a one-cycle flush pulse invalidates every line at once.

Both data ports use valid/ready. The processor raises `cpu_req_valid` and holds the request unchanged until it sees `cpu_req_ready`. Read data is valid in that same cycle. The cache holds a memory request stable while `mem_req_valid` is high and `mem_req_ready` is low. Read beats come back on `mem_rsp_valid` with no back-pressure: the cache accepts a beat in every cycle it is offered.

Top module: `urc_cache`

## Requirements
- R1: Address bits [3:2] pick the word in a line, bits [9:4] pick one of 64 sets, and bits [31:10] are the tag. After a fill, each of the four words of that line reads back its own memory value.
- R2: A read that hits raises `cpu_req_ready` in the same cycle as `cpu_req_valid`, returns the cached word and issues no memory request.
- R3: A read miss with the cacheable flag set and the cache enabled issues one memory read with `mem_req_len` = 3 (beats minus one) at the line-aligned address. It takes beats in order, word 0 first, and returns the requested word. It then installs the line.
- R4: A read miss with the cacheable flag clear issues one memory read with `mem_req_len` = 0 at the word-aligned address and returns that word. It installs nothing, so the same read misses again.
- R5: The lookup runs whatever the flag says: a hit with the flag clear returns cached data and makes no memory access.
- R6: After reset no line is valid and no request is pending. While `cache_en` is low, every read goes out as a single-word access, nothing hits and nothing is allocated. Writes then leave the arrays unchanged.
- R7: A `flush` pulse invalidates every line in one cycle, so the next read of any previously cached address misses.
- R8: Every write issues exactly one memory write (`mem_req_len` = 0, word-aligned address, processor data). A hit also updates the cached word, and a miss allocates no line.
- R9: The victim way is bits [1:0] of an 8-bit register. At reset the register holds 0x01. It steps every cycle to {q[6:0], q[7]^q[5]^q[4]^q[3]}. The value sampled is the one present on the edge where the fill request is accepted.
- R10: The processor sees `cpu_req_ready` only while it holds `cpu_req_valid`. The cache issues memory requests only on behalf of a pending processor request, and holds each one stable until it is accepted.
- R11: A fill into a way that already holds a valid line replaces it, and the evicted address misses afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cache_en | input | 1 | Cache enable level |
| flush | input | 1 | Invalidate all lines (one-cycle pulse) |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Request completes this cycle |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_cacheable | input | 1 | Read miss may allocate |
| cpu_req_addr | input | 32 | Virtual byte address |
| cpu_req_wdata | input | 32 | Write data |
| cpu_rd_data | output | 32 | Read data, valid with `cpu_req_ready` |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_write | output | 1 | 1 = write |
| mem_req_len | output | 2 | Beats minus one |
| mem_req_addr | output | 32 | Memory byte address |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read beat present |
| mem_rsp_data | input | 32 | Read beat data |

## Verification
The bench uses the default geometry: 64 sets, four ways, four words per line and an 8-bit victim generator. With only four ways, five tags aimed at one set are enough to force evictions whose victims the bench predicts from its own copy of the generator sequence. The small tag and set range of the mixed random phase makes hits, uncached misses, write hits and replacements all frequent. The bench also runs a phase with a memory that stalls and leaves gaps between beats, to exercise back-pressure on the request and the burst handling.

// File: rtl/urc_pkg.sv
package urc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RESP = 2'd2
  } urc_state_e;
endpackage

// File: rtl/urc_lfsr.sv
module urc_lfsr #(
  parameter int            W     = 8,
  parameter logic [W-1:0]  TAPS  = 8'hB8,
  parameter logic [W-1:0]  SEED  = 8'h01,
  parameter int            OUT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [OUT_W-1:0] pick
);
  logic [W-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= SEED;
    else        q <= {q[W-2:0], ^(q & TAPS)};
  end

  assign pick = q[OUT_W-1:0];

  // R9
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n) q != '0)
    else $error("lfsr locked at zero");
endmodule

// File: rtl/urc_tag_store.sv
module urc_tag_store #(
  parameter int SETS  = 64,
  parameter int WAYS  = 4,
  parameter int TAG_W = 22,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_en,
  input  logic [SET_W-1:0] lk_set,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             hit_any,
  output logic [WAY_W-1:0] hit_idx,
  input  logic             inst_en,
  input  logic [SET_W-1:0] inst_set,
  input  logic [WAY_W-1:0] inst_way,
  input  logic [TAG_W-1:0] inst_tag,
  input  logic             flush
);
  logic [SETS-1:0][WAYS-1:0] valid_q;
  logic [TAG_W-1:0]          tag_q [SETS][WAYS];
  logic [WAYS-1:0]           hit_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       valid_q <= '0;
    else if (flush)   valid_q <= '0;
    else if (inst_en) valid_q[inst_set][inst_way] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (inst_en) tag_q[inst_set][inst_way] <= inst_tag;
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = lk_en && valid_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
  end

  always_comb begin
    hit_idx = '0;
    for (int w = 0; w < WAYS; w++)
      if (hit_vec[w]) hit_idx = WAY_W'(w);
  end

  assign hit_any = |hit_vec;

  // R1
  hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit_vec))
    else $error("address hits in more than one way");

  // R7
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n) flush |=> (valid_q == '0))
    else $error("lines still valid after flush");
endmodule

// File: rtl/urc_data_store.sv
module urc_data_store #(
  parameter int SETS  = 64,
  parameter int WAYS  = 4,
  parameter int WORDS = 4,
  parameter int DW    = 32,
  localparam int SET_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int WORD_W = $clog2(WORDS),
  localparam int IDX_W  = SET_W + WAY_W + WORD_W,
  localparam int DEPTH  = SETS * WAYS * WORDS
) (
  input  logic              clk,
  input  logic [SET_W-1:0]  rd_set,
  input  logic [WAY_W-1:0]  rd_way,
  input  logic [WORD_W-1:0] rd_word,
  output logic [DW-1:0]     rd_data,
  input  logic              we,
  input  logic [SET_W-1:0]  wr_set,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [DW-1:0]     wr_data
);
  logic [DW-1:0]    mem_q [DEPTH];
  logic [IDX_W-1:0] rd_idx, wr_idx;

  assign rd_idx = {rd_set, rd_way, rd_word};
  assign wr_idx = {wr_set, wr_way, wr_word};

  always_ff @(posedge clk) begin
    if (we) mem_q[wr_idx] <= wr_data;
  end

  assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/urc_ctrl.sv
module urc_ctrl
  import urc_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int SETS  = 64,
  parameter int WAYS  = 4,
  parameter int WORDS = 4,
  localparam int BYTE_W  = $clog2(DW/8),
  localparam int WORD_W  = $clog2(WORDS),
  localparam int SET_W   = $clog2(SETS),
  localparam int WAY_W   = $clog2(WAYS),
  localparam int SET_LSB = BYTE_W + WORD_W,
  localparam int TAG_LSB = SET_LSB + SET_W,
  localparam int TAG_W   = AW - TAG_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cache_en,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic              cpu_req_cacheable,
  input  logic [AW-1:0]     cpu_req_addr,
  input  logic [DW-1:0]     cpu_req_wdata,
  output logic [DW-1:0]     cpu_rd_data,
  input  logic              hit_any,
  input  logic [WAY_W-1:0]  hit_idx,
  input  logic [DW-1:0]     hit_data,
  input  logic [WAY_W-1:0]  victim,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [WORD_W-1:0] mem_req_len,
  output logic [AW-1:0]     mem_req_addr,
  output logic [DW-1:0]     mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DW-1:0]     mem_rsp_data,
  output logic              dw_en,
  output logic [SET_W-1:0]  dw_set,
  output logic [WAY_W-1:0]  dw_way,
  output logic [WORD_W-1:0] dw_word,
  output logic [DW-1:0]     dw_data,
  output logic              inst_en,
  output logic [SET_W-1:0]  inst_set,
  output logic [TAG_W-1:0]  inst_tag
);
  localparam logic [AW-1:0] WORD_MASK = ~AW'(DW/8 - 1);
  localparam logic [AW-1:0] LINE_MASK = ~AW'(WORDS*DW/8 - 1);

  urc_state_e        state_q, state_d;
  logic [AW-1:0]     addr_q;
  logic              alloc_q;
  logic [WAY_W-1:0]  victim_q;
  logic [WORD_W-1:0] beat_q;
  logic [DW-1:0]     hold_q, hold_d;
  logic              fill_now, beat_last;

  assign fill_now  = cache_en && cpu_req_cacheable;
  assign beat_last = !alloc_q || (beat_q == WORD_W'(WORDS-1));

  always_comb begin
    state_d       = state_q;
    hold_d        = hold_q;
    cpu_req_ready = 1'b0;
    cpu_rd_data   = hold_q;
    mem_req_valid = 1'b0;
    mem_req_write = 1'b0;
    mem_req_len   = '0;
    mem_req_addr  = cpu_req_addr & WORD_MASK;
    mem_req_wdata = cpu_req_wdata;
    dw_en         = 1'b0;
    dw_set        = cpu_req_addr[SET_LSB +: SET_W];
    dw_way        = hit_idx;
    dw_word       = cpu_req_addr[BYTE_W +: WORD_W];
    dw_data       = cpu_req_wdata;
    inst_en       = 1'b0;
    inst_set      = addr_q[SET_LSB +: SET_W];
    inst_tag      = addr_q[TAG_LSB +: TAG_W];
    unique case (state_q)
      ST_IDLE: begin
        if (cpu_req_valid) begin
          if (cpu_req_write) begin
            mem_req_valid = 1'b1;
            mem_req_write = 1'b1;
            if (mem_req_ready) begin
              cpu_req_ready = 1'b1;
              dw_en         = hit_any;
            end
          end else if (hit_any) begin
            cpu_req_ready = 1'b1;
            cpu_rd_data   = hit_data;
          end else begin
            mem_req_valid = 1'b1;
            if (fill_now) begin
              mem_req_len  = WORD_W'(WORDS-1);
              mem_req_addr = cpu_req_addr & LINE_MASK;
            end
            if (mem_req_ready) state_d = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        dw_set  = addr_q[SET_LSB +: SET_W];
        dw_way  = victim_q;
        dw_word = beat_q;
        dw_data = mem_rsp_data;
        if (mem_rsp_valid) begin
          dw_en = alloc_q;
          if (!alloc_q || beat_q == addr_q[BYTE_W +: WORD_W]) hold_d = mem_rsp_data;
          if (beat_last) begin
            inst_en = alloc_q;
            state_d = ST_RESP;
          end
        end
      end
      ST_RESP: begin
        cpu_req_ready = 1'b1;
        state_d       = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      alloc_q  <= 1'b0;
      victim_q <= '0;
      beat_q   <= '0;
      hold_q   <= '0;
    end else begin
      state_q <= state_d;
      hold_q  <= hold_d;
      if (state_q == ST_IDLE && mem_req_valid && mem_req_ready && !mem_req_write) begin
        addr_q   <= cpu_req_addr;
        alloc_q  <= fill_now;
        victim_q <= victim;
        beat_q   <= '0;
      end else if (state_q == ST_WAIT && mem_rsp_valid) begin
        beat_q <= beat_q + 1'b1;
      end
    end
  end

  // R10
  mem_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_len))
    else $error("memory request changed before acceptance");

  // R10
  ready_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_ready |-> cpu_req_valid)
    else $error("ready without a request");

  // R4
  no_uncached_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && !alloc_q) |-> !dw_en && !inst_en)
    else $error("uncached miss touched the arrays");

  // R6
  off_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && mem_req_valid && !cache_en) |-> mem_req_len == '0)
    else $error("burst issued while disabled");
endmodule

// File: rtl/urc_cache.sv
module urc_cache #(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int SETS   = 64,
  parameter int WAYS   = 4,
  parameter int WORDS  = 4,
  parameter int RAND_W = 8,
  localparam int BYTE_W  = $clog2(DW/8),
  localparam int WORD_W  = $clog2(WORDS),
  localparam int SET_W   = $clog2(SETS),
  localparam int WAY_W   = $clog2(WAYS),
  localparam int SET_LSB = BYTE_W + WORD_W,
  localparam int TAG_LSB = SET_LSB + SET_W,
  localparam int TAG_W   = AW - TAG_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cache_en,
  input  logic              flush,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic              cpu_req_cacheable,
  input  logic [AW-1:0]     cpu_req_addr,
  input  logic [DW-1:0]     cpu_req_wdata,
  output logic [DW-1:0]     cpu_rd_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [WORD_W-1:0] mem_req_len,
  output logic [AW-1:0]     mem_req_addr,
  output logic [DW-1:0]     mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DW-1:0]     mem_rsp_data
);
  logic              hit_any;
  logic [WAY_W-1:0]  hit_idx, victim, dw_way;
  logic [DW-1:0]     hit_data, dw_data;
  logic              dw_en, inst_en;
  logic [SET_W-1:0]  dw_set, inst_set;
  logic [WORD_W-1:0] dw_word;
  logic [TAG_W-1:0]  inst_tag;

  urc_lfsr #(.W(RAND_W), .TAPS(RAND_W'(8'hB8)), .SEED(RAND_W'(1)), .OUT_W(WAY_W)) u_rand (
    .clk(clk), .rst_n(rst_n), .pick(victim)
  );

  urc_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .lk_en(cache_en),
    .lk_set(cpu_req_addr[SET_LSB +: SET_W]),
    .lk_tag(cpu_req_addr[TAG_LSB +: TAG_W]),
    .hit_any(hit_any), .hit_idx(hit_idx),
    .inst_en(inst_en), .inst_set(inst_set), .inst_way(dw_way), .inst_tag(inst_tag),
    .flush(flush)
  );

  urc_data_store #(.SETS(SETS), .WAYS(WAYS), .WORDS(WORDS), .DW(DW)) u_data (
    .clk(clk),
    .rd_set(cpu_req_addr[SET_LSB +: SET_W]), .rd_way(hit_idx),
    .rd_word(cpu_req_addr[BYTE_W +: WORD_W]), .rd_data(hit_data),
    .we(dw_en), .wr_set(dw_set), .wr_way(dw_way), .wr_word(dw_word), .wr_data(dw_data)
  );

  urc_ctrl #(.AW(AW), .DW(DW), .SETS(SETS), .WAYS(WAYS), .WORDS(WORDS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cache_en(cache_en),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_write(cpu_req_write), .cpu_req_cacheable(cpu_req_cacheable),
    .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata), .cpu_rd_data(cpu_rd_data),
    .hit_any(hit_any), .hit_idx(hit_idx), .hit_data(hit_data), .victim(victim),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_len(mem_req_len),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .dw_en(dw_en), .dw_set(dw_set), .dw_way(dw_way), .dw_word(dw_word), .dw_data(dw_data),
    .inst_en(inst_en), .inst_set(inst_set), .inst_tag(inst_tag)
  );
endmodule

// File: tb/urc_cache_tb_top.sv
`timescale 1ns/1ps
module urc_cache_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, cache_en, flush;
  logic cpu_req_valid, cpu_req_ready, cpu_req_write, cpu_req_cacheable;
  logic [31:0] cpu_req_addr, cpu_req_wdata, cpu_rd_data;
  logic mem_req_valid, mem_req_ready, mem_req_write;
  logic [1:0] mem_req_len;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic mem_rsp_valid;
  logic [31:0] mem_rsp_data;

  urc_cache dut_i (.*);

  int n_tests = 0, n_fail = 0;
  bit in_access = 0, slow = 0, en_model = 0, shown = 0;
  int cyc = 0;

  bit          m_valid [64][4];
  int          m_tag   [64][4];
  logic [31:0] m_data  [64][4][4];
  logic [7:0]  m_lfsr;

  logic [31:0] mem_aa [int unsigned];
  logic [31:0] rq_addr[$], rq_wdata[$], beat_q[$], fill_words[$];
  logic [1:0]  rq_len[$];
  bit          rq_wr[$];
  int          rq_vict[$];

  // R9 reference sequence of the victim generator
  always @(posedge clk or negedge rst_n)
    if (!rst_n) m_lfsr <= 8'h01;
    else        m_lfsr <= {m_lfsr[6:0], m_lfsr[7] ^ m_lfsr[5] ^ m_lfsr[4] ^ m_lfsr[3]};

  function automatic logic [31:0] mem_rd(logic [31:0] a);
    if (mem_aa.exists(a)) return mem_aa[a];
    return (a * 32'h9E37_79B1) ^ 32'h1234_5678;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // observer: a handshake seen here completes on the next rising edge
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (cpu_req_ready && !cpu_req_valid) chk(0, "R10 ready w/o valid", 1, 0);
      if (mem_req_valid && !in_access)     chk(0, "R10 stray mem req", 1, 0);
      if (mem_req_valid && mem_req_ready) begin
        rq_addr.push_back(mem_req_addr);
        rq_len.push_back(mem_req_len);
        rq_wr.push_back(mem_req_write);
        rq_wdata.push_back(mem_req_wdata);
        rq_vict.push_back(int'(m_lfsr[1:0]));
        if (mem_req_write) mem_aa[mem_req_addr] = mem_req_wdata;
        else begin
          for (int b = 0; b <= int'(mem_req_len); b++) begin
            beat_q.push_back(mem_rd(mem_req_addr + 32'(4*b)));
            fill_words.push_back(mem_rd(mem_req_addr + 32'(4*b)));
          end
        end
      end
    end
  end

  // memory responder
  always @(posedge clk) begin
    #1;
    cyc++;
    if (shown) void'(beat_q.pop_front());
    mem_req_ready = slow ? (cyc % 3 != 0) : 1'b1;
    mem_rsp_valid = (beat_q.size() > 0) && (!slow || (cyc % 2 == 0));
    mem_rsp_data  = (beat_q.size() > 0) ? beat_q[0] : 32'h0;
    shown = mem_rsp_valid;
  end

  task automatic access(bit wr, logic [31:0] a, logic [31:0] wd, bit cach, string req);
    int set = int'(a[9:4]);
    int tag = int'(a[31:10]);
    int word = int'(a[3:2]);
    int hw = -1;
    int n = 0;
    bit fill;
    logic [31:0] expv, got;
    if (en_model)
      for (int w = 0; w < 4; w++) if (m_valid[set][w] && m_tag[set][w] == tag) hw = w;
    fill = !wr && hw < 0 && en_model && cach;
    expv = (hw >= 0) ? m_data[set][hw][word] : mem_rd(a & ~32'h3);
    rq_addr.delete(); rq_len.delete(); rq_wr.delete(); rq_wdata.delete();
    rq_vict.delete(); fill_words.delete();
    @(negedge clk);
    cpu_req_valid = 1; cpu_req_write = wr; cpu_req_addr = a;
    cpu_req_wdata = wd; cpu_req_cacheable = cach; in_access = 1;
    #1;
    while (!cpu_req_ready && n < 500) begin @(negedge clk); #1; n++; end
    got = cpu_rd_data;
    @(negedge clk);
    cpu_req_valid = 0; in_access = 0;
    if (n >= 500) begin chk(0, {"hang ", req}, 0, 1); return; end
    if (wr) begin
      chk(rq_addr.size() == 1 && rq_wr[0] && rq_len[0] == 0 && rq_addr[0] == (a & ~32'h3)
          && rq_wdata[0] == wd, {"R8 ", req}, rq_addr.size(), 1);
      if (hw >= 0) m_data[set][hw][word] = wd;
    end else if (hw >= 0) begin
      chk(n == 0 && rq_addr.size() == 0, {"R2 ", req}, n, 0);
      chk(got == expv, {"R2 data ", req}, got, expv);
    end else if (fill) begin
      chk(rq_addr.size() == 1 && !rq_wr[0] && rq_len[0] == 3 && rq_addr[0] == (a & ~32'hF),
          {"R3 ", req}, rq_addr.size() ? rq_addr[0] : 0, a & ~32'hF);
      chk(got == expv, {"R3 data ", req}, got, expv);
      if (rq_vict.size() == 1 && fill_words.size() == 4) begin
        m_valid[set][rq_vict[0]] = 1;
        m_tag[set][rq_vict[0]] = tag;
        for (int k = 0; k < 4; k++) m_data[set][rq_vict[0]][k] = fill_words[k];
      end
    end else begin
      chk(rq_addr.size() == 1 && !rq_wr[0] && rq_len[0] == 0 && rq_addr[0] == (a & ~32'h3),
          {en_model ? "R4 " : "R6 ", req}, rq_addr.size() ? rq_addr[0] : 0, a & ~32'h3);
      chk(got == expv, {"single data ", req}, got, expv);
    end
  endtask

  task automatic set_en(bit v);
    @(negedge clk); cache_en = v; en_model = v;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
    foreach (m_valid[s, w]) m_valid[s][w] = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] a0;
    rst_n = 0; cache_en = 0; flush = 0;
    cpu_req_valid = 0; cpu_req_write = 0; cpu_req_cacheable = 0;
    cpu_req_addr = 0; cpu_req_wdata = 0;
    mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = 0;
    foreach (m_valid[s, w]) m_valid[s][w] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(!cpu_req_ready && !mem_req_valid, "R6 reset idle", {cpu_req_ready, mem_req_valid}, 0);

    // disabled: external single reads, no allocation
    a0 = 32'h0000_4A30;
    access(0, a0, 0, 1, "R6 off read");
    access(0, a0, 0, 1, "R6 off reread");

    set_en(1);
    access(0, a0 + 4, 0, 1, "R3 first fill");
    for (int k = 0; k < 4; k++) access(0, a0 + 32'(4*k), 0, 1, "R1 word select");
    access(0, a0 + 8, 0, 0, "R5 hit uncacheable");

    access(0, 32'h0000_8B70, 0, 0, "R4 uncached miss");
    access(0, 32'h0000_8B70, 0, 0, "R4 no install");

    access(1, a0 + 4, 32'hCAFE_0001, 1, "R8 write hit");
    access(0, a0 + 4, 0, 1, "R8 updated word");
    access(1, 32'h0001_2340, 32'hBEEF_0002, 1, "R8 write miss");
    access(0, 32'h0001_2340, 0, 0, "R8 no allocate");

    set_en(0);
    access(0, a0, 0, 1, "R6 off bypass");
    access(1, a0 + 4, 32'h1111_2222, 1, "R6 off write");
    set_en(1);
    access(0, a0 + 4, 0, 1, "R6 stale kept");

    // evictions in one set with a stalling memory
    slow = 1;
    for (int t = 0; t < 6; t++) access(0, 32'h0040_0000 + 32'(t << 10) + 32'h50, 0, 1, "R9 fill");
    for (int t = 0; t < 6; t++) access(0, 32'h0040_0000 + 32'(t << 10) + 32'h5C, 0, 1, "R11 revisit");
    slow = 0;

    do_flush();
    access(0, a0, 0, 1, "R7 miss after flush");
    access(0, 32'h0040_0050, 0, 0, "R7 uncached after flush");

    for (int i = 0; i < 200; i++) begin
      logic [31:0] ra;
      ra = (32'($urandom % 6) << 10) | (32'($urandom % 3) << 4) | (32'($urandom % 4) << 2);
      if (i % 50 == 49) set_en(!en_model);
      access(($urandom % 4) == 0, ra, $urandom, ($urandom % 3) != 0, "mix");
      if (i % 70 == 69) do_flush();
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule